// File: doc/BRIEF.md
# Flash embedded operation status engine

This block is the internal program/erase engine of a small byte-wide flash. A command decoder gives it one request at a time: program a byte, erase a sector, or erase the whole chip. The engine then drives an external storage array. It issues a single read-modify-write strobe for a program. For an erase it issues sector fill strobes: zeros first, then ones. The time each operation takes is set by cycle-count parameters.

While an operation runs, bus reads do not see the array. They get a status byte instead. Bit 7 is a data-polling flag and bit 6 is a toggle flag. When the engine is idle, reads return the array contents or, in identifier mode, the manufacturer code, the boot-variant code or the boot-block lock state.

The boot block is the group of `BOOT_SECTORS` sectors at the top of the address space (`TOP_BOOT=1`) or at the bottom (`TOP_BOOT=0`). While the lock input is high, the engine refuses any program or sector erase aimed at that group. A chip erase leaves the group untouched.

Top module: `flash_op_engine`

## Requirements
- R1: After reset, `busy_o`, `arr_we_o`, `arr_fill_o` and `rd_data_o` are all 0.
- R2: A program request (`req_op_i`=01) keeps `busy_o` high for exactly `PROG_CYCLES` cycles. It makes one `arr_we_o` pulse, in the last busy cycle, at the request address, writing the request data ANDed with the old contents. Program can only clear bits.
- R3: A read while busy returns, one cycle later, bit 7 as the complement of bit 7 of the program data. For an erase, bit 7 is 0. Bits 5..0 are 0.
- R4: Bit 6 of busy reads is 0 on the first read after an operation is accepted and inverts on each later busy read.
- R5: A read while idle with identifier mode off returns the array byte at `rd_addr_i` one cycle after `rd_en_i`.
- R6: A sector erase (`req_op_i`=10) is busy for 2*`PHASE_CYCLES` cycles. It fills the addressed sector with 00H at the end of the first phase and with FFH at the end of the second.
- R7: A chip erase (`req_op_i`=11) is busy for 2*`PHASE_CYCLES`*sectors cycles. It processes the sectors in ascending order, filling each with 00H and then FFH.
- R8: With the lock high, a program or sector erase aimed at a boot sector is refused. It is busy for `REFUSE_CYCLES` cycles and issues no write or fill.
- R9: A chip erase accepted with the lock high issues no fill to boot sectors. Its duration stays the same as in R7.
- R10: A request that arrives while busy is ignored.
- R11: In identifier mode while idle, address bits [1:0] select what is read back. 00 gives 40H. Bit 0 set gives 01H for the top-boot variant or A1H for the bottom-boot variant. 10 gives 01H when locked and 00H when unlocked.
- R12: The lock state is sampled when a request is accepted. Changing it later does not affect that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe from the command decoder |
| req_op_i | input | 2 | 00 none, 01 program, 10 sector erase, 11 chip erase |
| req_addr_i | input | ADDR_W | Target byte or sector address |
| req_data_i | input | 8 | Program data |
| boot_lock_i | input | 1 | Boot-block lock state |
| rd_en_i | input | 1 | Bus read strobe |
| rd_addr_i | input | ADDR_W | Bus read address |
| autosel_i | input | 1 | Identifier read mode |
| rd_data_o | output | 8 | Read data, one cycle after `rd_en_i` |
| busy_o | output | 1 | Operation in progress |
| arr_addr_o | output | ADDR_W | Array address: the held target while programming, otherwise `rd_addr_i` |
| arr_rdata_i | input | 8 | Array read data, combinational from `arr_addr_o` |
| arr_we_o | output | 1 | Array byte write strobe |
| arr_wdata_o | output | 8 | Array byte write data |
| arr_fill_o | output | 1 | Sector fill strobe |
| arr_fill_val_o | output | 8 | Sector fill value |
| arr_sector_o | output | ADDR_W-SECTOR_W | Sector to fill |

## Verification
The assertions assume that the array read port is combinational and that `req_op_i` is stable while `req_valid_i` is high. The bench models the array with a combinational read. It drives each request for exactly one cycle and changes no input near a clock edge. Reads issued during an operation are kept short enough to finish inside it, so each busy read is known to return status rather than array data.

// File: rtl/flash_op_pkg.sv
package flash_op_pkg;
  typedef enum logic [1:0] {OP_NONE = 2'b00, OP_PROG = 2'b01, OP_SERASE = 2'b10, OP_CERASE = 2'b11} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_PROG, ST_ERASE, ST_REFUSE} state_e;
  localparam logic [7:0] MFR_CODE  = 8'h40;
  localparam logic [7:0] ID_TOP    = 8'h01;
  localparam logic [7:0] ID_BOTTOM = 8'hA1;
  localparam logic [7:0] FILL_ZERO = 8'h00;
  localparam logic [7:0] FILL_ONE  = 8'hFF;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/fop_timer.sv
module fop_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/fop_seq.sv
module fop_seq
  import flash_op_pkg::*;
#(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned SECTOR_W      = 9,
  parameter int unsigned BOOT_SECTORS  = 16,
  parameter bit          TOP_BOOT      = 1'b1,
  parameter int unsigned PROG_CYCLES   = 16,
  parameter int unsigned PHASE_CYCLES  = 8,
  parameter int unsigned REFUSE_CYCLES = 4,
  localparam int unsigned SEC_IDX_W    = ADDR_W - SECTOR_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [1:0]           req_op_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [7:0]           req_data_i,
  input  logic                 boot_lock_i,
  input  logic [7:0]           arr_rdata_i,
  output logic                 busy_o,
  output logic                 start_o,
  output logic                 stat_b7_o,
  output logic                 prog_sel_o,
  output logic [ADDR_W-1:0]    prog_addr_o,
  output logic                 arr_we_o,
  output logic [7:0]           arr_wdata_o,
  output logic                 arr_fill_o,
  output logic [7:0]           arr_fill_val_o,
  output logic [SEC_IDX_W-1:0] arr_sector_o
);
  localparam int unsigned NUM_SECTORS = 1 << SEC_IDX_W;
  localparam int unsigned MAX_LIM     = max3(PROG_CYCLES, PHASE_CYCLES, REFUSE_CYCLES);
  localparam int unsigned CNT_W       = (MAX_LIM < 2) ? 1 : $clog2(MAX_LIM);
  localparam logic [CNT_W-1:0] PROG_LIM   = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] PHASE_LIM  = CNT_W'(PHASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] REFUSE_LIM = CNT_W'(REFUSE_CYCLES - 1);
  localparam logic [SEC_IDX_W-1:0] LAST_SEC = SEC_IDX_W'(NUM_SECTORS - 1);

  state_e               state_q, state_d;
  logic [ADDR_W-1:0]    addr_q;
  logic [7:0]           data_q;
  logic [SEC_IDX_W-1:0] sec_q;
  logic                 phase_q, chip_q, lock_q, b7_q;
  logic                 accept, done, boot_req, boot_cur, skip_fill;
  logic [CNT_W-1:0]     lim;
  logic [SEC_IDX_W-1:0] req_sec;
  op_e                  op;

  assign op      = op_e'(req_op_i);
  assign req_sec = req_addr_i[ADDR_W-1:SECTOR_W];
  assign accept  = req_valid_i && (state_q == ST_IDLE) && (op != OP_NONE);

  generate
    if (TOP_BOOT) begin : g_top_boot
      assign boot_req = req_sec >= SEC_IDX_W'(NUM_SECTORS - BOOT_SECTORS);
      assign boot_cur = sec_q   >= SEC_IDX_W'(NUM_SECTORS - BOOT_SECTORS);
    end else begin : g_bottom_boot
      assign boot_req = req_sec < SEC_IDX_W'(BOOT_SECTORS);
      assign boot_cur = sec_q   < SEC_IDX_W'(BOOT_SECTORS);
    end
  endgenerate

  always_comb begin
    unique case (state_q)
      ST_PROG:  lim = PROG_LIM;
      ST_ERASE: lim = PHASE_LIM;
      default:  lim = REFUSE_LIM;
    endcase
  end

  fop_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .en_i   (state_q != ST_IDLE),
    .lim_i  (lim),
    .done_o (done)
  );

  assign skip_fill = chip_q && lock_q && boot_cur;

  always_comb begin
    state_d = state_q;
    if (accept) begin
      unique case (op)
        OP_PROG:   state_d = (boot_lock_i && boot_req) ? ST_REFUSE : ST_PROG;
        OP_SERASE: state_d = (boot_lock_i && boot_req) ? ST_REFUSE : ST_ERASE;
        default:   state_d = ST_ERASE;
      endcase
    end else if (done) begin
      unique case (state_q)
        ST_ERASE: state_d = (phase_q && !(chip_q && sec_q != LAST_SEC)) ? ST_IDLE : ST_ERASE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      sec_q   <= '0;
      phase_q <= 1'b0;
      chip_q  <= 1'b0;
      lock_q  <= 1'b0;
      b7_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= req_addr_i;
        data_q  <= req_data_i;
        phase_q <= 1'b0;
        chip_q  <= (op == OP_CERASE);
        lock_q  <= boot_lock_i;
        sec_q   <= (op == OP_CERASE) ? '0 : req_sec;
        b7_q    <= (op == OP_PROG) ? ~req_data_i[7] : 1'b0;
      end else if (done && state_q == ST_ERASE) begin
        if (!phase_q) begin
          phase_q <= 1'b1;
        end else if (chip_q && sec_q != LAST_SEC) begin
          phase_q <= 1'b0;
          sec_q   <= sec_q + 1'b1;
        end
      end
    end
  end

  assign busy_o         = state_q != ST_IDLE;
  assign start_o        = accept;
  assign stat_b7_o      = b7_q;
  assign prog_sel_o     = state_q == ST_PROG;
  assign prog_addr_o    = addr_q;
  assign arr_we_o       = (state_q == ST_PROG) && done;
  assign arr_wdata_o    = data_q & arr_rdata_i;
  assign arr_fill_o     = (state_q == ST_ERASE) && done && !skip_fill;
  assign arr_fill_val_o = phase_q ? FILL_ONE : FILL_ZERO;
  assign arr_sector_o   = sec_q;
endmodule

// File: rtl/fop_status.sv
module fop_status
  import flash_op_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic       start_i,
  input  logic       stat_b7_i,
  input  logic       rd_en_i,
  input  logic       autosel_i,
  input  logic [1:0] rd_addr_lo_i,
  input  logic       boot_lock_i,
  input  logic [7:0] arr_rdata_i,
  output logic [7:0] rd_data_o
);
  localparam logic [7:0] DEV_ID = TOP_BOOT ? ID_TOP : ID_BOTTOM;

  logic       tog_q;
  logic [7:0] rd_q, id_byte, rd_d;

  always_comb begin
    if (rd_addr_lo_i[0])      id_byte = DEV_ID;
    else if (rd_addr_lo_i[1]) id_byte = {7'b0, boot_lock_i};
    else                      id_byte = MFR_CODE;
  end

  always_comb begin
    if (busy_i)         rd_d = {stat_b7_i, tog_q, 6'b0};
    else if (autosel_i) rd_d = id_byte;
    else                rd_d = arr_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      if (start_i)                tog_q <= 1'b0;
      else if (rd_en_i && busy_i) tog_q <= ~tog_q;
      if (rd_en_i) rd_q <= rd_d;
    end
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import flash_op_pkg::*;
#(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned SECTOR_W      = 9,
  parameter int unsigned BOOT_SECTORS  = 16,
  parameter bit          TOP_BOOT      = 1'b1,
  parameter int unsigned PROG_CYCLES   = 16,
  parameter int unsigned PHASE_CYCLES  = 8,
  parameter int unsigned REFUSE_CYCLES = 4,
  localparam int unsigned SEC_IDX_W    = ADDR_W - SECTOR_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [1:0]           req_op_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [7:0]           req_data_i,
  input  logic                 boot_lock_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  input  logic                 autosel_i,
  output logic [7:0]           rd_data_o,
  output logic                 busy_o,
  output logic [ADDR_W-1:0]    arr_addr_o,
  input  logic [7:0]           arr_rdata_i,
  output logic                 arr_we_o,
  output logic [7:0]           arr_wdata_o,
  output logic                 arr_fill_o,
  output logic [7:0]           arr_fill_val_o,
  output logic [SEC_IDX_W-1:0] arr_sector_o
);
  logic              start, stat_b7, prog_sel;
  logic [ADDR_W-1:0] prog_addr;

  fop_seq #(
    .ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .BOOT_SECTORS(BOOT_SECTORS), .TOP_BOOT(TOP_BOOT),
    .PROG_CYCLES(PROG_CYCLES), .PHASE_CYCLES(PHASE_CYCLES), .REFUSE_CYCLES(REFUSE_CYCLES)
  ) i_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_op_i       (req_op_i),
    .req_addr_i     (req_addr_i),
    .req_data_i     (req_data_i),
    .boot_lock_i    (boot_lock_i),
    .arr_rdata_i    (arr_rdata_i),
    .busy_o         (busy_o),
    .start_o        (start),
    .stat_b7_o      (stat_b7),
    .prog_sel_o     (prog_sel),
    .prog_addr_o    (prog_addr),
    .arr_we_o       (arr_we_o),
    .arr_wdata_o    (arr_wdata_o),
    .arr_fill_o     (arr_fill_o),
    .arr_fill_val_o (arr_fill_val_o),
    .arr_sector_o   (arr_sector_o)
  );

  // array port is borrowed for the read-modify-write while programming
  assign arr_addr_o = prog_sel ? prog_addr : rd_addr_i;

  fop_status #(.TOP_BOOT(TOP_BOOT)) i_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       (busy_o),
    .start_i      (start),
    .stat_b7_i    (stat_b7),
    .rd_en_i      (rd_en_i),
    .autosel_i    (autosel_i),
    .rd_addr_lo_i (rd_addr_i[1:0]),
    .boot_lock_i  (boot_lock_i),
    .arr_rdata_i  (arr_rdata_i),
    .rd_data_o    (rd_data_o)
  );
endmodule

// File: rtl/fop_checker.sv
module fop_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       arr_we_o,
  input logic       arr_fill_o,
  input logic [7:0] arr_fill_val_o,
  input logic       rd_en_i,
  input logic [7:0] rd_data_o
);
  assert_we_ends_op_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |=> !busy_o);

  assert_we_only_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> busy_o);

  assert_status_low_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && busy_o) |=> (rd_data_o[5:0] == 6'b0));

  assert_fill_value_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_fill_o |-> (arr_fill_val_o == 8'h00 || arr_fill_val_o == 8'hFF));

  assert_single_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({arr_we_o, arr_fill_o}));

  assert_fill_only_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_fill_o |-> busy_o);
endmodule

bind flash_op_engine fop_checker i_fop_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .busy_o         (busy_o),
  .arr_we_o       (arr_we_o),
  .arr_fill_o     (arr_fill_o),
  .arr_fill_val_o (arr_fill_val_o),
  .rd_en_i        (rd_en_i),
  .rd_data_o      (rd_data_o)
);

// File: tb/test_flash_op_engine.sv
module test_flash_op_engine;
  localparam int AW = 12, SW = 6, SIW = AW - SW, NSEC = 1 << SIW, SECB = 1 << SW;
  localparam int BOOTS = 4, PROGC = 10, PHASEC = 3, REFC = 4;
  localparam int MEMN = 1 << AW;
  localparam int BOOT_BASE = (NSEC - BOOTS) * SECB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, boot_lock = 0, rd_en = 0, autosel = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0, rd_addr = 0, arr_addr;
  logic [7:0] req_data = 0, rd_data, arr_rdata, arr_wdata, fill_val;
  logic busy, arr_we, arr_fill;
  logic [SIW-1:0] arr_sector;

  logic [7:0] mem [MEMN];
  logic [7:0] ref_mem [MEMN];
  int fsec [256];
  int fval [256];
  int fcnt, we_cnt;
  int we_addr;
  logic log_clr = 0;
  int nchk = 0, nfail = 0;
  logic done_flag = 0;

  always #2.5 clk = ~clk;

  flash_op_engine #(
    .ADDR_W(AW), .SECTOR_W(SW), .BOOT_SECTORS(BOOTS), .TOP_BOOT(1'b1),
    .PROG_CYCLES(PROGC), .PHASE_CYCLES(PHASEC), .REFUSE_CYCLES(REFC)
  ) i_flash_op_engine (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_data_i(req_data), .boot_lock_i(boot_lock),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .autosel_i(autosel), .rd_data_o(rd_data),
    .busy_o(busy), .arr_addr_o(arr_addr), .arr_rdata_i(arr_rdata), .arr_we_o(arr_we),
    .arr_wdata_o(arr_wdata), .arr_fill_o(arr_fill), .arr_fill_val_o(fill_val),
    .arr_sector_o(arr_sector)
  );

  assign arr_rdata = mem[arr_addr];

  // array model and strobe log
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMN; i++) mem[i] <= 8'hFF;
    end else begin
      if (arr_we) mem[arr_addr] <= arr_wdata;
      if (arr_fill)
        for (int i = 0; i < SECB; i++) mem[{arr_sector, SW'(i)}] <= fill_val;
    end
    if (log_clr) begin
      fcnt <= 0; we_cnt <= 0;
    end else begin
      if (arr_fill) begin
        fsec[fcnt[7:0]] <= int'(arr_sector);
        fval[fcnt[7:0]] <= int'(fill_val);
        fcnt <= fcnt + 1;
      end
      if (arr_we) begin
        we_cnt <= we_cnt + 1;
        we_addr <= int'(arr_addr);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr_log();
    @(negedge clk); log_clr = 1;
    @(negedge clk); log_clr = 0;
  endtask

  task automatic issue(input logic [1:0] op, input int addr, input int data);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = AW'(addr); req_data = 8'(data);
    @(negedge clk);
    req_valid = 0; req_op = 0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
  endtask

  task automatic run_op(input logic [1:0] op, input int addr, input int data, output int cyc);
    clr_log();
    issue(op, addr, data);
    wait_idle(cyc);
  endtask

  task automatic rd(input int addr, output logic [7:0] d);
    @(negedge clk); rd_en = 1; rd_addr = AW'(addr);
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  function automatic logic [7:0] id_exp(input int a, input bit lock);
    if (a % 2 == 1) return 8'h01;
    if ((a / 2) % 2 == 1) return {7'b0, lock};
    return 8'h40;
  endfunction

  function automatic bit is_boot(input int a);
    return a >= BOOT_BASE;
  endfunction

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int cyc, a, a2, d;
    logic [7:0] v;
    void'($urandom(32'h1f2e3d4c));
    for (int i = 0; i < MEMN; i++) ref_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk(busy == 0 && arr_we == 0 && arr_fill == 0 && rd_data == 0, "R1 reset", int'(rd_data), 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R1 idle after reset", int'(busy), 0);

    // R11 identifier reads, both lock states
    autosel = 1;
    for (int l = 0; l < 2; l++) begin
      boot_lock = l[0];
      for (int k = 0; k < 4; k++) begin
        rd(k, v);
        chk(v == id_exp(k, l[0]), "R11 identifier", int'(v), int'(id_exp(k, l[0])));
      end
    end
    autosel = 0; boot_lock = 0;

    // R2 R5 random programs outside boot block
    for (int n = 0; n < 24; n++) begin
      a = int'($urandom % BOOT_BASE);
      d = int'($urandom % 256);
      run_op(2'b01, a, d, cyc);
      ref_mem[a] = ref_mem[a] & 8'(d);
      chk(cyc == PROGC, "R2 program duration", cyc, PROGC);
      chk(we_cnt == 1 && we_addr == a, "R2 single write at target", we_addr, a);
      rd(a, v);
      chk(v == ref_mem[a], "R5 R2 read back AND result", int'(v), int'(ref_mem[a]));
    end

    // R3 R4 polling status during program; R10 request while busy ignored
    a = 100; a2 = 200;
    clr_log();
    issue(2'b01, a, 8'h35);
    ref_mem[a] = ref_mem[a] & 8'h35;
    for (int k = 0; k < 3; k++) begin
      rd(a, v);
      chk(v[7] == 1'b1, "R3 bit7 complement", int'(v[7]), 1);
      chk(v[6] == k[0], "R4 toggle", int'(v[6]), k & 1);
      chk(v[5:0] == 0, "R3 low bits", int'(v[5:0]), 0);
    end
    issue(2'b01, a2, 8'h00);
    wait_idle(cyc);
    chk(we_cnt == 1, "R10 ignored request", we_cnt, 1);
    rd(a2, v);
    chk(v == ref_mem[a2], "R10 untouched byte", int'(v), int'(ref_mem[a2]));
    rd(a, v);
    chk(v == ref_mem[a], "R5 true data after op", int'(v), int'(ref_mem[a]));

    // R6 sector erase of sector 1, status bit7 = 0
    clr_log();
    issue(2'b10, 70, 0);
    rd(70, v);
    chk(v[7] == 0 && v[6] == 0, "R3 R4 erase status", int'(v), 0);
    wait_idle(cyc);
    chk(cyc == 2 * PHASEC - 2, "R6 erase duration", cyc + 2, 2 * PHASEC);
    chk(fcnt == 2 && fsec[0] == 1 && fval[0] == 0 && fsec[1] == 1 && fval[1] == 255,
        "R6 fill sequence", fcnt, 2);
    for (int i = 0; i < SECB; i++) ref_mem[SECB + i] = 8'hFF;
    rd(70, v);
    chk(v == 8'hFF, "R6 erased reads FF", int'(v), 255);
    rd(a, v);
    chk(v == ref_mem[a], "R6 other sector kept", int'(v), int'(ref_mem[a]));

    // R12 lock raised after acceptance does not refuse
    a = BOOT_BASE + 5;
    clr_log();
    issue(2'b01, a, 8'h0F);
    boot_lock = 1;
    wait_idle(cyc);
    ref_mem[a] = ref_mem[a] & 8'h0F;
    chk(we_cnt == 1, "R12 lock sampled at accept", we_cnt, 1);
    rd(a, v);
    chk(v == ref_mem[a], "R12 boot byte programmed", int'(v), int'(ref_mem[a]));

    // R8 refused program and sector erase on locked boot block
    run_op(2'b01, a, 8'h00, cyc);
    chk(cyc == REFC && we_cnt == 0, "R8 refused program", cyc, REFC);
    run_op(2'b10, a, 0, cyc);
    chk(cyc == REFC && fcnt == 0, "R8 refused erase", fcnt, 0);
    rd(a, v);
    chk(v == ref_mem[a], "R8 boot byte unchanged", int'(v), int'(ref_mem[a]));

    // R9 chip erase under lock
    run_op(2'b11, 0, 0, cyc);
    chk(cyc == 2 * PHASEC * NSEC, "R9 chip erase duration", cyc, 2 * PHASEC * NSEC);
    chk(fcnt == 2 * (NSEC - BOOTS), "R9 boot sectors skipped", fcnt, 2 * (NSEC - BOOTS));
    chk(fsec[fcnt - 1] == NSEC - BOOTS - 1 && fval[fcnt - 1] == 255, "R9 last fill", fsec[fcnt - 1], NSEC - BOOTS - 1);
    for (int i = 0; i < BOOT_BASE; i++) ref_mem[i] = 8'hFF;
    rd(a, v);
    chk(v == ref_mem[a], "R9 boot data kept", int'(v), int'(ref_mem[a]));
    rd(100, v);
    chk(v == 8'hFF, "R9 main array erased", int'(v), 255);

    // R7 full chip erase unlocked
    boot_lock = 0;
    run_op(2'b11, 0, 0, cyc);
    chk(cyc == 2 * PHASEC * NSEC, "R7 chip erase duration", cyc, 2 * PHASEC * NSEC);
    chk(fcnt == 2 * NSEC, "R7 fill count", fcnt, 2 * NSEC);
    begin
      bit ok = 1;
      for (int s = 0; s < NSEC; s++)
        if (fsec[2*s] != s || fsec[2*s+1] != s || fval[2*s] != 0 || fval[2*s+1] != 255) ok = 0;
      chk(ok, "R7 ascending zero then one", int'(ok), 1);
    end
    rd(a, v);
    chk(v == 8'hFF, "R7 boot erased", int'(v), 255);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule